// File: doc/BRIEF.md
# Four-Channel Gated Timing Pulse Generator

This block turns the timing strobes of four independent discriminator channels into output logic pulses of programmable width. Each strobe is a single-cycle request. Before a strobe can start or extend a pulse, the channel qualifies it against three conditions:

- its own gate input, in either coincidence or anticoincidence sense;
- a shared fast veto input;
- a shared slow bin gate.

Every channel drives three identical copies of its pulse. It also drives an event flag, which is held high for a fixed number of cycles after each accepted strobe.

Each channel can run in one of two modes, selected at runtime. In updating mode a new strobe restarts the width timer. In blocking mode a strobe that arrives while the pulse is active is ignored. The width is a 10-bit cycle code with a range multiplier. All inputs and outputs are synchronous to one clock. The per-channel configuration and the bin-gate master switch are captured into registers on every clock edge, and the captured values govern the following cycle.

The gate and veto levels are judged over a short window that ends at the strobe cycle. The veto window reaches further back than the gate window, so a veto that starts slightly before the strobe still blocks it.

Top module: `pulse_gen_quad`

## Requirements
- R1: In blocking mode (update bit 0), a strobe seen while the channel output is high starts nothing and leaves the remaining width unchanged. A strobe seen while the output is low starts a pulse.
- R2: In updating mode (update bit 1), an accepted strobe loads the full effective width. The output then stays high for exactly that many cycles, counted from the cycle after the strobe, even when a pulse is already running.
- R3: The effective width in cycles is max(code,1) shifted left by the range field. Range 0 gives x1, range 1 gives x2, and ranges 2 and 3 give x4 in blocking mode. In updating mode, ranges 2 and 3 fall back to x2.
- R4: The gate is judged over a window made of the strobe cycle plus the GATE_LEAD cycles before it. With the sense bit at 0 (coincidence), the gate must be high in every cycle of that window. With the sense bit at 1 (anticoincidence), the gate must be low in every cycle of that window.
- R5: A channel whose veto-enable bit is 1 rejects a strobe when the veto input is high in the strobe cycle or in any of the VETO_LEAD cycles before it. A channel whose veto-enable bit is 0 ignores the veto.
- R6: A strobe is rejected when three conditions hold in the strobe cycle: the channel's bin-enable bit is 1, the registered bin master switch is 1, and the bin gate input is high. Otherwise the bin gate has no effect.
- R7: Each accepted strobe sets the channel's event flag high from the next cycle for HOLD_CYC cycles, restarting on every accepted strobe.
- R8: The N_COPIES output bits of a channel, at positions ch*N_COPIES+k, are always equal.
- R9: While reset is asserted, and in the first cycle after it is released, all outputs and event flags are low. The configuration registers reset to blocking mode, coincidence, all enables off, range 0 and code 0.
- R10: A configuration input takes effect on strobes one cycle after it is applied, because it passes through a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strobe_i | input | N_CH | Per-channel timing strobe |
| gate_i | input | N_CH | Per-channel gate level |
| veto_i | input | 1 | Shared fast veto level |
| bin_gate_i | input | 1 | Shared slow inhibit level |
| bin_master_i | input | 1 | Global bin-gate on switch |
| upd_mode_i | input | N_CH | 1 = updating, 0 = blocking |
| gate_anti_i | input | N_CH | 1 = anticoincidence, 0 = coincidence |
| veto_en_i | input | N_CH | Channel responds to veto |
| bin_en_i | input | N_CH | Channel responds to bin gate |
| width_i | input | N_CH*W_BITS | Width code, channel c at [c*W_BITS +: W_BITS] |
| range_i | input | N_CH*2 | Range field, channel c at [c*2 +: 2] |
| out_o | output | N_CH*N_COPIES | Output pulse copies |
| event_o | output | N_CH | Stretched event flag |

## Verification
The bench keeps the default W_BITS=10, GATE_LEAD=1 and VETO_LEAD=2. Because the gate window is two cycles and the veto window three, a single-cycle gate and a veto that leads the strobe by two or by three cycles each land on a window edge. HOLD_CYC is lowered to 40 so that the event flag visibly expires and restarts many times within a short run. Random width codes are kept small, so strobes often collide with running pulses in both modes. A directed case with code 1023 exercises the top of the width counter.

// File: rtl/pulse_gen_pkg.sv
package pulse_gen_pkg;
  localparam int RNG_BITS = 2;
  localparam logic [RNG_BITS-1:0] RNG_X1 = 2'd0;
  localparam logic [RNG_BITS-1:0] RNG_X2 = 2'd1;

  typedef struct packed {
    logic                upd;
    logic                anti;
    logic                veto_en;
    logic                bin_en;
    logic [RNG_BITS-1:0] rng;
  } chan_mode_t;
endpackage

// File: rtl/lead_window.sv
module lead_window #(
  parameter int DEPTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sig_i,
  output logic [DEPTH-1:0] hist_o
);
  logic [DEPTH-1:0] hist_q;

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q <= '0;
        else         hist_q <= sig_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q <= '0;
        else         hist_q <= {hist_q[DEPTH-2:0], sig_i};
      end
    end
  endgenerate

  assign hist_o = hist_q;

  p_lead_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sig_i |=> hist_o[0]);
endmodule

// File: rtl/width_timer.sv
module width_timer import pulse_gen_pkg::*; #(
  parameter int W_BITS = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                upd_i,
  input  logic [W_BITS-1:0]   width_i,
  input  logic [RNG_BITS-1:0] rng_i,
  output logic                fire_o,
  output logic                active_o
);
  localparam int CNT_W = W_BITS + 2;
  localparam logic [CNT_W-1:0] UPD_CAP = {1'b0, {W_BITS{1'b1}}, 1'b0};

  logic [CNT_W-1:0]  cnt_q, eff;
  logic [W_BITS-1:0] wcode;

  always_comb begin
    wcode = (width_i == '0) ? W_BITS'(1) : width_i;
    if (rng_i == RNG_X1)      eff = {2'b00, wcode};
    else if (rng_i == RNG_X2) eff = {1'b0, wcode, 1'b0};
    else if (upd_i)           eff = {1'b0, wcode, 1'b0};  // widest range not allowed
    else                      eff = {wcode, 2'b00};
  end

  assign active_o = (cnt_q != '0);
  assign fire_o   = req_i && (upd_i || !active_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (fire_o)    cnt_q <= eff;
    else if (active_o)  cnt_q <= cnt_q - 1'b1;
  end

  p_block_keep_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_upd_restart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && req_i) |=> (cnt_q == $past(eff)));
  p_upd_cap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && req_i) |=> (cnt_q <= UPD_CAP));
  p_min_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> active_o);
endmodule

// File: rtl/event_hold.sv
module event_hold #(
  parameter int HOLD_CYC = 1 << 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic busy_o
);
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);

  logic [HOLD_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             hold_q <= '0;
    else if (fire_i)         hold_q <= HOLD_W'(HOLD_CYC);
    else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
  end

  assign busy_o = (hold_q != '0);

  p_event_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> busy_o);
  p_event_decay_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fire_i && hold_q != '0) |=> (hold_q == $past(hold_q) - 1'b1));
endmodule

// File: rtl/chan_unit.sv
module chan_unit import pulse_gen_pkg::*; #(
  parameter int W_BITS    = 10,
  parameter int GATE_LEAD = 1,
  parameter int HOLD_CYC  = 1 << 20
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                strobe_i,
  input  logic                gate_i,
  input  logic                veto_win_i,
  input  logic                veto_raw_i,
  input  logic                bin_block_i,
  input  logic                upd_i,
  input  logic                anti_i,
  input  logic                veto_en_i,
  input  logic                bin_en_i,
  input  logic [RNG_BITS-1:0] rng_i,
  input  logic [W_BITS-1:0]   width_i,
  output logic                pulse_o,
  output logic                event_o
);
  chan_mode_t        mode_q;
  logic [W_BITS-1:0] width_q;
  logic [GATE_LEAD-1:0] gate_hist;
  logic gate_all, gate_any, gate_ok, req, fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      width_q <= '0;
    end else begin
      mode_q  <= '{upd: upd_i, anti: anti_i, veto_en: veto_en_i,
                   bin_en: bin_en_i, rng: rng_i};
      width_q <= width_i;
    end
  end

  lead_window #(.DEPTH(GATE_LEAD)) i_gate_win (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (gate_i),
    .hist_o(gate_hist)
  );

  assign gate_all = gate_i & (&gate_hist);
  assign gate_any = gate_i | (|gate_hist);
  assign gate_ok  = mode_q.anti ? !gate_any : gate_all;
  assign req = strobe_i && gate_ok
            && !(mode_q.veto_en && veto_win_i)
            && !(mode_q.bin_en && bin_block_i);

  width_timer #(.W_BITS(W_BITS)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req),
    .upd_i   (mode_q.upd),
    .width_i (width_q),
    .rng_i   (mode_q.rng),
    .fire_o  (fire),
    .active_o(pulse_o)
  );

  event_hold #(.HOLD_CYC(HOLD_CYC)) i_event (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fire_i(fire),
    .busy_o(event_o)
  );

  p_coin_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q.anti && !gate_i) |-> !fire);
  p_anti_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.anti && gate_i) |-> !fire);
  p_veto_block_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.veto_en && veto_raw_i) |-> !fire);
  p_bin_block_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.bin_en && bin_block_i) |-> !fire);
  p_cfg_latency_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (mode_q.upd == $past(upd_i)));
endmodule

// File: rtl/pulse_gen_quad.sv
module pulse_gen_quad import pulse_gen_pkg::*; #(
  parameter int N_CH      = 4,
  parameter int N_COPIES  = 3,
  parameter int W_BITS    = 10,
  parameter int GATE_LEAD = 1,
  parameter int VETO_LEAD = 2,
  parameter int HOLD_CYC  = 1 << 20
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_CH-1:0]              strobe_i,
  input  logic [N_CH-1:0]              gate_i,
  input  logic                         veto_i,
  input  logic                         bin_gate_i,
  input  logic                         bin_master_i,
  input  logic [N_CH-1:0]              upd_mode_i,
  input  logic [N_CH-1:0]              gate_anti_i,
  input  logic [N_CH-1:0]              veto_en_i,
  input  logic [N_CH-1:0]              bin_en_i,
  input  logic [N_CH*W_BITS-1:0]       width_i,
  input  logic [N_CH*RNG_BITS-1:0]     range_i,
  output logic [N_CH*N_COPIES-1:0]     out_o,
  output logic [N_CH-1:0]              event_o
);
  logic [VETO_LEAD-1:0] veto_hist;
  logic                 veto_win, bin_master_q, bin_block;
  logic [N_CH-1:0]      pulse;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bin_master_q <= 1'b0;
    else         bin_master_q <= bin_master_i;
  end

  lead_window #(.DEPTH(VETO_LEAD)) i_veto_win (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (veto_i),
    .hist_o(veto_hist)
  );

  assign veto_win  = veto_i | (|veto_hist);
  assign bin_block = bin_master_q & bin_gate_i;

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      chan_unit #(
        .W_BITS   (W_BITS),
        .GATE_LEAD(GATE_LEAD),
        .HOLD_CYC (HOLD_CYC)
      ) i_chan (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .strobe_i   (strobe_i[c]),
        .gate_i     (gate_i[c]),
        .veto_win_i (veto_win),
        .veto_raw_i (veto_i),
        .bin_block_i(bin_block),
        .upd_i      (upd_mode_i[c]),
        .anti_i     (gate_anti_i[c]),
        .veto_en_i  (veto_en_i[c]),
        .bin_en_i   (bin_en_i[c]),
        .rng_i      (range_i[c*RNG_BITS +: RNG_BITS]),
        .width_i    (width_i[c*W_BITS +: W_BITS]),
        .pulse_o    (pulse[c]),
        .event_o    (event_o[c])
      );
      for (genvar k = 0; k < N_COPIES; k++) begin : g_copy
        assign out_o[c*N_COPIES + k] = pulse[c];
      end
    end
  endgenerate

  p_rst_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (out_o == '0));
  p_evt_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse[0]) |-> event_o[0]);
endmodule

// File: tb/test_pulse_gen_quad.sv
module test_pulse_gen_quad;
  localparam int N = 4, C = 3, WB = 10, GL = 1, VL = 2, HOLD = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0]    strobe_i = '0, gate_i = '0, upd_i = '0, anti_i = '0;
  logic [N-1:0]    ven_i = '0, ben_i = '0;
  logic            veto_i = 1'b0, bin_gate_i = 1'b0, bin_master_i = 1'b0;
  logic [N*WB-1:0] width_i = '0;
  logic [N*2-1:0]  range_i = '0;
  logic [N*C-1:0]  out_o;
  logic [N-1:0]    event_o;

  pulse_gen_quad #(.N_CH(N), .N_COPIES(C), .W_BITS(WB), .GATE_LEAD(GL),
                   .VETO_LEAD(VL), .HOLD_CYC(HOLD)) i_pulse_gen_quad (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe_i), .gate_i(gate_i),
    .veto_i(veto_i), .bin_gate_i(bin_gate_i), .bin_master_i(bin_master_i),
    .upd_mode_i(upd_i), .gate_anti_i(anti_i), .veto_en_i(ven_i),
    .bin_en_i(ben_i), .width_i(width_i), .range_i(range_i),
    .out_o(out_o), .event_o(event_o));

  int checks = 0, errors = 0;
  bit done = 0;
  string phase = "R9 reset";

  // reference state
  int m_cnt[N], m_hold[N], m_rng[N], m_w[N];
  bit m_upd[N], m_anti[N], m_ven[N], m_ben[N];
  bit m_binm;
  bit [7:0] vhist;
  bit [7:0] ghist[N];

  function automatic int eff_width(int w, int r, bit upd);
    int wc = (w == 0) ? 1 : w;
    int sh = (r == 0) ? 0 : ((r == 1) ? 1 : (upd ? 1 : 2));
    return wc << sh;
  endfunction

  function automatic bit gate_pass(bit anti, bit now, bit [7:0] h);
    bit all_hi = now, any_hi = now;
    for (int i = 0; i < GL; i++) begin
      all_hi &= h[i];
      any_hi |= h[i];
    end
    return anti ? !any_hi : all_hi;
  endfunction

  task automatic model_step();
    bit vwin = veto_i;
    for (int i = 0; i < VL; i++) vwin |= vhist[i];
    for (int c = 0; c < N; c++) begin
      bit ok, fire;
      ok = strobe_i[c] && gate_pass(m_anti[c], gate_i[c], ghist[c])
           && !(m_ven[c] && vwin) && !(m_ben[c] && m_binm && bin_gate_i);
      fire = ok && (m_upd[c] || m_cnt[c] == 0);
      if (fire) m_cnt[c] = eff_width(m_w[c], m_rng[c], m_upd[c]);
      else if (m_cnt[c] > 0) m_cnt[c]--;
      if (fire) m_hold[c] = HOLD;
      else if (m_hold[c] > 0) m_hold[c]--;
      ghist[c] = {ghist[c][6:0], gate_i[c]};
      m_upd[c] = upd_i[c]; m_anti[c] = anti_i[c]; m_ven[c] = ven_i[c];
      m_ben[c] = ben_i[c]; m_rng[c] = int'(range_i[c*2 +: 2]);
      m_w[c] = int'(width_i[c*WB +: WB]);
    end
    vhist = {vhist[6:0], veto_i};
    m_binm = bin_master_i;
  endtask

  task automatic check_outputs();
    for (int c = 0; c < N; c++) begin
      bit exp_o = (m_cnt[c] != 0);
      bit exp_e = (m_hold[c] != 0);
      for (int k = 0; k < C; k++) begin
        checks++;
        if (out_o[c*C+k] !== exp_o) begin
          errors++;
          $display("FAIL [%s] R8 ch%0d copy%0d out act=%0b exp=%0b",
                   phase, c, k, out_o[c*C+k], exp_o);
        end
      end
      checks++;
      if (event_o[c] !== exp_e) begin
        errors++;
        $display("FAIL [%s] R7 ch%0d event act=%0b exp=%0b",
                 phase, c, event_o[c], exp_e);
      end
    end
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    check_outputs();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic hit(int c);
    strobe_i[c] = 1'b1;
    tick();
    strobe_i[c] = 1'b0;
  endtask

  task automatic set_cfg(int c, bit upd, bit anti, bit ven, bit ben, int r, int w);
    upd_i[c] = upd; anti_i[c] = anti; ven_i[c] = ven; ben_i[c] = ben;
    range_i[c*2 +: 2] = 2'(r);
    width_i[c*WB +: WB] = WB'(w);
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL [watchdog] run did not finish act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    for (int c = 0; c < N; c++) begin
      m_cnt[c] = 0; m_hold[c] = 0; m_rng[c] = 0; m_w[c] = 0;
      m_upd[c] = 0; m_anti[c] = 0; m_ven[c] = 0; m_ben[c] = 0; ghist[c] = '0;
    end
    m_binm = 0; vhist = '0;
    repeat (3) @(negedge clk);
    // R9: quiet while in reset
    checks++;
    if (out_o !== '0 || event_o !== '0) begin
      errors++;
      $display("FAIL [R9 reset] outputs act=%0h/%0h exp=0/0", out_o, event_o);
    end
    rst_n = 1'b1;
    check_outputs();

    phase = "R1 blocking retrigger";
    set_cfg(0, 0, 0, 0, 0, 0, 5);
    gate_i = '1;
    idle(2);
    hit(0); idle(2); hit(0); idle(1); hit(0); idle(8);

    phase = "R2 updating restart";
    set_cfg(1, 1, 0, 0, 0, 0, 5);
    idle(1);
    hit(1); idle(2); hit(1); idle(1); hit(1); idle(9);

    phase = "R3 width ranges";
    set_cfg(2, 0, 0, 0, 0, 0, 0); idle(1); hit(2); idle(3);
    set_cfg(2, 0, 0, 0, 0, 2, 3); idle(1); hit(2); idle(14);
    set_cfg(2, 1, 0, 0, 0, 2, 3); idle(1); hit(2); idle(8);
    set_cfg(2, 1, 0, 0, 0, 3, 3); idle(1); hit(2); idle(8);
    set_cfg(3, 0, 0, 0, 0, 0, 1023); idle(1); hit(3); idle(1030);

    phase = "R4 gate window";
    gate_i = '0; idle(3);
    hit(0); idle(6);
    gate_i[0] = 1'b1; hit(0); idle(6);
    gate_i[0] = 1'b1; tick(); hit(0); gate_i[0] = 1'b0; idle(6);
    set_cfg(0, 0, 1, 0, 0, 0, 4);
    hit(0); idle(5);
    gate_i[0] = 1'b1; tick(); gate_i[0] = 1'b0; hit(0); idle(5);
    idle(1); hit(0); idle(5);

    phase = "R5 veto window";
    gate_i = '1;
    set_cfg(0, 0, 0, 1, 0, 0, 3); set_cfg(1, 0, 0, 0, 0, 0, 3); idle(2);
    veto_i = 1'b1; tick(); veto_i = 1'b0; tick();
    strobe_i[1:0] = 2'b11; tick(); strobe_i = '0; idle(5);
    veto_i = 1'b1; tick(); veto_i = 1'b0; idle(2);
    strobe_i[1:0] = 2'b11; tick(); strobe_i = '0; idle(5);
    veto_i = 1'b1; strobe_i[1:0] = 2'b11; tick(); veto_i = 1'b0; strobe_i = '0; idle(5);

    phase = "R6 bin gate";
    set_cfg(0, 0, 0, 0, 1, 0, 3); set_cfg(1, 0, 0, 0, 0, 0, 3);
    bin_gate_i = 1'b1; idle(1);
    strobe_i[1:0] = 2'b11; tick(); strobe_i = '0; idle(4);
    bin_master_i = 1'b1; tick();
    strobe_i[1:0] = 2'b11; tick(); strobe_i = '0; idle(4);
    bin_gate_i = 1'b0;
    strobe_i[1:0] = 2'b11; tick(); strobe_i = '0; idle(4);

    phase = "R10 config latency";
    upd_i[0] = 1'b1; hit(0); hit(0); idle(6);

    phase = "R7 event hold";
    idle(HOLD + 5); hit(0); idle(10); hit(0); idle(HOLD + 3);

    phase = "R1 R2 R3 R4 R5 R6 random";
    for (int i = 0; i < 4000; i++) begin
      if (i % 120 == 0) begin
        for (int c = 0; c < N; c++) begin
          upd_i[c] = 1'($urandom_range(1)); anti_i[c] = ($urandom_range(3) == 0);
          ven_i[c] = 1'($urandom_range(1)); ben_i[c] = 1'($urandom_range(1));
          range_i[c*2 +: 2] = 2'($urandom_range(3));
          width_i[c*WB +: WB] = WB'($urandom_range(8));
        end
        bin_master_i = 1'($urandom_range(1));
      end
      for (int c = 0; c < N; c++) begin
        strobe_i[c] = ($urandom_range(9) < 3);
        if ($urandom_range(9) < 3) gate_i[c] = ~gate_i[c];
      end
      veto_i = ($urandom_range(9) == 0);
      bin_gate_i = ($urandom_range(4) == 0);
      tick();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule